// File: doc/BRIEF.md
# Discontiguous Queue Entry Address Resolver

This block finds the host memory address of a single fixed-size entry in a queue whose storage is scattered across pages. The queue is described by a chain of pointer-list pages. Every 8-byte slot in a list page holds the address of one data page, except the final slot, which links to the next list page in the chain. The caller gives the page size and entry size as log2 values, the queue index and the address of the first list page, then pulses a start strobe.

The resolver first splits the index into a data page number and an entry within that page. It then hops along the chain as many times as needed. Each hop is one 8-byte read of a link slot. Next it reads the pointer to the chosen data page and adds the byte offset of the entry within that page. Reads go out on a single-beat request/response port. The result is presented together with a one-cycle done pulse. Every pointer is taken to be page-aligned.

Top module: `dqe_addr_resolver`

## Requirements
- R1: When the data page number is smaller than the number of data slots per list page, exactly one read is issued, at list base + data page number × 8. The returned pointer plus the entry offset is the result.
- R2: With entries per page = 2^(pg_log2_i − ent_log2_i), the data page number is idx_i / entries per page. The entry offset in bytes is (idx_i mod entries per page) × 2^ent_log2_i.
- R3: A list page holds 2^(pg_log2_i − 3) slots, of which slots − 1 point to data pages. The block makes data page number / (slots − 1) hops. Each hop reads current base + (slots − 1) × 8, and the returned value becomes the new base.
- R4: After the hops, one read is made at the current base + (data page number mod (slots − 1)) × 8. Its returned value plus the entry offset gives addr_o.
- R5: busy_o rises on the cycle after a start seen while idle, and it stays high until done. A start while busy_o is high has no effect on the reads or on the result.
- R6: done_o is high for exactly one cycle, with the result valid on addr_o. addr_o then holds its value until the next request completes.
- R7: rd_req_o is high for a single cycle per read. No new read is issued until rd_rvalid_i has returned the previous one.
- R8: During and right after reset, busy_o, done_o and rd_req_o are low.
- R9: A data page number equal to slots − 1 causes exactly one hop and a slot-0 read. A data page number of slots − 2 causes no hop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a resolution (taken only while idle) |
| pg_log2_i | input | LOG_W | log2 of page size in bytes (at least 4) |
| ent_log2_i | input | LOG_W | log2 of entry size in bytes (not above pg_log2_i) |
| idx_i | input | IDX_W | Queue entry index |
| list_base_i | input | ADDR_W | Address of the first pointer-list page |
| rd_req_o | output | 1 | Read request strobe, one cycle |
| rd_addr_o | output | ADDR_W | Read address, valid with rd_req_o |
| rd_rvalid_i | input | 1 | Read response valid |
| rd_rdata_i | input | ADDR_W | Read response data (8 bytes) |
| busy_o | output | 1 | Resolution in progress |
| done_o | output | 1 | Result valid pulse |
| addr_o | output | ADDR_W | Resolved entry address |

## Verification
The hardest case to reach is a walk over several list pages, where the link slot and the data-slot remainder sit right at a list boundary. With large pages this needs huge indices. The stimulus therefore uses 32-byte pages, which give three data slots per list page, so that a small index forces two hops, and an index equal to the slot count forces a single hop to slot zero. A bench memory model decodes every read address into a list page and a slot, and returns either a chain link or a page-aligned data pointer. Response latency is varied, and a second start is injected in the middle of a walk.

// File: rtl/dqe_pkg.sv
package dqe_pkg;
  localparam int unsigned PTR_LOG2 = 3;  // 8-byte pointers

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_HOP_REQ,
    ST_HOP_WAIT,
    ST_SEL_REQ,
    ST_SEL_WAIT,
    ST_DONE
  } walk_state_e;
endpackage

// File: rtl/dqe_index_calc.sv
module dqe_index_calc #(
  parameter int unsigned ADDR_W = 64,
  parameter int unsigned IDX_W  = 16,
  parameter int unsigned LOG_W  = 5
) (
  input  logic [LOG_W-1:0]  pg_log2_i,
  input  logic [LOG_W-1:0]  ent_log2_i,
  input  logic [IDX_W-1:0]  idx_i,
  output logic [ADDR_W-1:0] data_pg_o,
  output logic [ADDR_W-1:0] ent_ofs_o,
  output logic [ADDR_W-1:0] slots_o
);
  import dqe_pkg::*;

  logic [LOG_W-1:0]  epp_log2;
  logic [LOG_W-1:0]  ppp_log2;
  logic [ADDR_W-1:0] idx_ext;
  logic [ADDR_W-1:0] in_pg_mask;

  always_comb begin
    epp_log2   = pg_log2_i - ent_log2_i;
    ppp_log2   = pg_log2_i - LOG_W'(PTR_LOG2);
    idx_ext    = ADDR_W'(idx_i);
    in_pg_mask = (ADDR_W'(1) << epp_log2) - ADDR_W'(1);
    data_pg_o  = idx_ext >> epp_log2;
    ent_ofs_o  = (idx_ext & in_pg_mask) << ent_log2_i;
    // last pointer slot is reserved for the chain link
    slots_o    = (ADDR_W'(1) << ppp_log2) - ADDR_W'(1);
  end
endmodule

// File: rtl/dqe_walk_fsm.sv
module dqe_walk_fsm #(
  parameter int unsigned ADDR_W = 64
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] data_pg_i,
  input  logic [ADDR_W-1:0] ent_ofs_i,
  input  logic [ADDR_W-1:0] slots_i,
  input  logic [ADDR_W-1:0] list_base_i,
  output logic              rd_req_o,
  output logic [ADDR_W-1:0] rd_addr_o,
  input  logic              rd_rvalid_i,
  input  logic [ADDR_W-1:0] rd_rdata_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [ADDR_W-1:0] addr_o
);
  import dqe_pkg::*;

  walk_state_e       state_q;
  logic [ADDR_W-1:0] base_q, rem_q, slots_q, ofs_q, addr_q;
  logic [ADDR_W-1:0] rem_after_hop;

  assign rem_after_hop = rem_q - slots_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      base_q  <= '0;
      rem_q   <= '0;
      slots_q <= '0;
      ofs_q   <= '0;
      addr_q  <= '0;
    end else begin
      case (state_q)
        ST_IDLE: if (start_i) begin
          base_q  <= list_base_i;
          rem_q   <= data_pg_i;
          slots_q <= slots_i;
          ofs_q   <= ent_ofs_i;
          state_q <= (data_pg_i >= slots_i) ? ST_HOP_REQ : ST_SEL_REQ;
        end
        ST_HOP_REQ: state_q <= ST_HOP_WAIT;
        ST_HOP_WAIT: if (rd_rvalid_i) begin
          base_q  <= rd_rdata_i;
          rem_q   <= rem_after_hop;
          state_q <= (rem_after_hop >= slots_q) ? ST_HOP_REQ : ST_SEL_REQ;
        end
        ST_SEL_REQ: state_q <= ST_SEL_WAIT;
        ST_SEL_WAIT: if (rd_rvalid_i) begin
          addr_q  <= rd_rdata_i + ofs_q;
          state_q <= ST_DONE;
        end
        ST_DONE: state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    rd_req_o  = (state_q == ST_HOP_REQ) || (state_q == ST_SEL_REQ);
    rd_addr_o = (state_q == ST_HOP_REQ) ? base_q + (slots_q << 3)
                                        : base_q + (rem_q << 3);
    busy_o    = (state_q != ST_IDLE);
    done_o    = (state_q == ST_DONE);
    addr_o    = addr_q;
  end
endmodule

// File: rtl/dqe_addr_resolver.sv
module dqe_addr_resolver #(
  parameter int unsigned ADDR_W = 64,
  parameter int unsigned IDX_W  = 16,
  parameter int unsigned LOG_W  = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [LOG_W-1:0]  pg_log2_i,
  input  logic [LOG_W-1:0]  ent_log2_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic [ADDR_W-1:0] list_base_i,
  output logic              rd_req_o,
  output logic [ADDR_W-1:0] rd_addr_o,
  input  logic              rd_rvalid_i,
  input  logic [ADDR_W-1:0] rd_rdata_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [ADDR_W-1:0] addr_o
);
  logic [ADDR_W-1:0] data_pg, ent_ofs, slots;

  dqe_index_calc #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .LOG_W(LOG_W)) calc_i (
    .pg_log2_i (pg_log2_i),
    .ent_log2_i(ent_log2_i),
    .idx_i     (idx_i),
    .data_pg_o (data_pg),
    .ent_ofs_o (ent_ofs),
    .slots_o   (slots)
  );

  dqe_walk_fsm #(.ADDR_W(ADDR_W)) walk_i (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start_i),
    .data_pg_i  (data_pg),
    .ent_ofs_i  (ent_ofs),
    .slots_i    (slots),
    .list_base_i(list_base_i),
    .rd_req_o   (rd_req_o),
    .rd_addr_o  (rd_addr_o),
    .rd_rvalid_i(rd_rvalid_i),
    .rd_rdata_i (rd_rdata_i),
    .busy_o     (busy_o),
    .done_o     (done_o),
    .addr_o     (addr_o)
  );
endmodule

// File: rtl/dqe_addr_resolver_chk.sv
module dqe_addr_resolver_chk #(
  parameter int unsigned ADDR_W = 64
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              start_i,
  input logic              rd_req_o,
  input logic              busy_o,
  input logic              done_o,
  input logic [ADDR_W-1:0] addr_o
);
  a_r7_req_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_req_o |=> !rd_req_o);

  a_r7_req_in_walk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_req_o |-> busy_o && !done_o);

  a_r6_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  a_r6_done_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> busy_o);

  a_r6_addr_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |=> $stable(addr_o));

  a_r5_busy_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && start_i) |=> busy_o);

  a_r5_busy_until_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !done_o) |=> busy_o);
endmodule

bind dqe_addr_resolver dqe_addr_resolver_chk #(.ADDR_W(ADDR_W)) chk_i (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .start_i (start_i),
  .rd_req_o(rd_req_o),
  .busy_o  (busy_o),
  .done_o  (done_o),
  .addr_o  (addr_o)
);

// File: tb/dqe_addr_resolver_tb_top.sv
module dqe_addr_resolver_tb_top;
  localparam int ADDR_W = 64;
  localparam int IDX_W  = 16;
  localparam int LOG_W  = 5;
  localparam logic [63:0] LIST0   = 64'h1000_0000;
  localparam logic [63:0] LSTRIDE = 64'h0010_0000;
  localparam logic [63:0] DATA0   = 64'h8000_0000;

  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b0;
  logic              start_i = 1'b0;
  logic [LOG_W-1:0]  pg_log2_i = '0;
  logic [LOG_W-1:0]  ent_log2_i = '0;
  logic [IDX_W-1:0]  idx_i = '0;
  logic [ADDR_W-1:0] list_base_i = '0;
  logic              rd_req_o;
  logic [ADDR_W-1:0] rd_addr_o;
  logic              rd_rvalid_i = 1'b0;
  logic [ADDR_W-1:0] rd_rdata_i = '0;
  logic              busy_o, done_o;
  logic [ADDR_W-1:0] addr_o;

  always #4 clk_i = ~clk_i;  // 125 MHz

  dqe_addr_resolver #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .LOG_W(LOG_W)) dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i),
    .pg_log2_i(pg_log2_i), .ent_log2_i(ent_log2_i), .idx_i(idx_i),
    .list_base_i(list_base_i), .rd_req_o(rd_req_o), .rd_addr_o(rd_addr_o),
    .rd_rvalid_i(rd_rvalid_i), .rd_rdata_i(rd_rdata_i),
    .busy_o(busy_o), .done_o(done_o), .addr_o(addr_o)
  );

  int n_chk = 0, n_bad = 0;
  int cur_pg = 12, lat = 1, rd_cnt = 0, proto_bad = 0;
  logic [63:0] rd_log [64];

  task automatic chk(bit ok, string req, string what, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // list page k at LIST0 + k*LSTRIDE; link slot -> next list page; data slot s -> data page k*slots+s
  function automatic logic [63:0] mem_val(logic [63:0] a);
    logic [63:0] k, off, slots;
    k     = (a - LIST0) / LSTRIDE;
    off   = (a - LIST0) % LSTRIDE;
    slots = (64'd1 << (cur_pg - 3)) - 64'd1;
    if (off == slots * 8) return LIST0 + (k + 1) * LSTRIDE;
    return DATA0 + ((k * slots + off / 8) << cur_pg);
  endfunction

  // memory responder, R7 protocol check: no request while a read is outstanding
  initial begin
    forever begin
      @(negedge clk_i);
      while (rd_req_o) begin
        if (rd_cnt < 64) rd_log[rd_cnt] = rd_addr_o;
        rd_cnt++;
        rd_rdata_i = mem_val(rd_addr_o);
        for (int i = 0; i < lat; i++) begin
          @(negedge clk_i);
          if (rd_req_o) proto_bad++;
        end
        rd_rvalid_i = 1'b1;
        @(negedge clk_i);
        rd_rvalid_i = 1'b0;
      end
    end
  end

  task automatic run_case(string req, int pg, int ent, int idx, int l, bit intrude);
    longint epp, dpg, ein, slots, hops, rem;
    logic [63:0] exp_addr;
    int cyc;
    epp   = 64'd1 << (pg - ent);
    dpg   = idx / epp;
    ein   = idx % epp;
    slots = (64'd1 << (pg - 3)) - 1;
    hops  = dpg / slots;
    rem   = dpg % slots;
    exp_addr = DATA0 + (64'(dpg) << pg) + (64'(ein) << ent);
    cur_pg = pg; lat = l; rd_cnt = 0; proto_bad = 0;
    @(negedge clk_i);
    pg_log2_i = LOG_W'(pg); ent_log2_i = LOG_W'(ent); idx_i = IDX_W'(idx);
    list_base_i = LIST0; start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    chk(busy_o === 1'b1, "R5", "busy after start", 64'(busy_o), 64'd1);
    if (intrude) begin
      idx_i = IDX_W'(1); list_base_i = 64'hdead_0000; start_i = 1'b1;
      @(negedge clk_i);
      start_i = 1'b0;
    end
    cyc = 0;
    while (!done_o && cyc < 5000) begin
      @(negedge clk_i);
      cyc++;
      if (!done_o) chk(busy_o === 1'b1, "R5", "busy held", 64'(busy_o), 64'd1);
    end
    chk(done_o === 1'b1, req, "done seen", 64'(done_o), 64'd1);
    chk(addr_o === exp_addr, req, "entry address", addr_o, exp_addr);
    chk(rd_cnt == hops + 1, "R3", "read count", 64'(rd_cnt), 64'(hops + 1));
    for (int h = 0; h < hops && h < 63; h++)
      chk(rd_log[h] === LIST0 + 64'(h) * LSTRIDE + 64'(slots) * 8, "R3", "hop read addr",
          rd_log[h], LIST0 + 64'(h) * LSTRIDE + 64'(slots) * 8);
    if (hops < 63)
      chk(rd_log[hops] === LIST0 + 64'(hops) * LSTRIDE + 64'(rem) * 8, "R4", "select read addr",
          rd_log[hops], LIST0 + 64'(hops) * LSTRIDE + 64'(rem) * 8);
    chk(proto_bad == 0, "R7", "request while outstanding", 64'(proto_bad), 64'd0);
    @(negedge clk_i);
    chk(done_o === 1'b0, "R6", "done one cycle", 64'(done_o), 64'd0);
    chk(busy_o === 1'b0, "R5", "idle after done", 64'(busy_o), 64'd0);
    chk(addr_o === exp_addr, "R6", "address held", addr_o, exp_addr);
  endtask

  task automatic t_reset;
    chk(busy_o === 1'b0 && done_o === 1'b0 && rd_req_o === 1'b0, "R8", "outputs in reset",
        {61'd0, busy_o, done_o, rd_req_o}, 64'd0);
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(busy_o === 1'b0 && done_o === 1'b0 && rd_req_o === 1'b0, "R8", "outputs after reset",
        {61'd0, busy_o, done_o, rd_req_o}, 64'd0);
  endtask

  task automatic t_first_list;
    run_case("R1", 12, 6, 5, 1, 1'b0);
    run_case("R1", 12, 6, 200, 2, 1'b0);
  endtask

  task automatic t_entry_offset;
    run_case("R2", 12, 4, 300, 1, 1'b0);
    run_case("R2", 9, 9, 7, 3, 1'b0);
  endtask

  task automatic t_hops;
    run_case("R3", 5, 3, 30, 1, 1'b0);
    run_case("R4", 12, 6, 65411, 2, 1'b0);
    run_case("R4", 4, 2, 37, 1, 1'b0);
  endtask

  task automatic t_boundary;
    run_case("R9", 5, 3, 12, 1, 1'b0);
    run_case("R9", 5, 3, 11, 1, 1'b0);
  endtask

  task automatic t_start_ignored;
    run_case("R5", 5, 3, 30, 3, 1'b1);
  endtask

  task automatic summary;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    n_bad++;
    $display("FAIL watchdog R5: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    t_reset();
    t_first_list();
    t_entry_offset();
    t_hops();
    t_boundary();
    t_start_ignored();
    summary();
    $finish;
  end
endmodule